// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns parallel bytes from a host write port into asynchronous serial frames on a single line. Bytes pass through three storage stages in order: a small write queue, a one-byte holding stage and a shift stage. The shift stage drives the line. Each stage refills from the stage behind it as soon as it empties, so the shift stage can begin a new frame on the same cycle the previous stop bit ends.

A frame is a low start bit, then 5 to 8 data bits sent least-significant bit first, then an optional parity bit, then a high stop bit. A 2-bit word-size field picks the number of data bits. Two further configuration bits enable parity and choose its sense. Bit time is measured in pulses of an external baud tick input, with a fixed number of ticks per bit.

Three status outputs are provided. The first shows that the holding stage is free. The second shows that the whole path is drained and the line is idle. The third is a sticky flag that records a byte lost to a full queue.

Top module: `uart_tx_pipe`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `line_idle` is 1 and `overrun` is 0.
- R2: Every bit of a frame lasts exactly OSR asserted `baud_tick` pulses. The start bit is 0, data bits follow least-significant first, the stop bit is 1, and the line idles at 1. `txd` changes only on a clock edge where `baud_tick` is 1 or where a new frame begins.
- R3: `cfg_wsize` selects the data bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Only the low bits of the byte are sent.
- R4: When `cfg_par_on` is 1, one parity bit follows the data bits. It is the XOR of the sent data bits when `cfg_par_odd` is 0 (even parity), and its inverse when `cfg_par_odd` is 1. When `cfg_par_on` is 0, no parity bit is sent.
- R5: `hold_empty` is 1 exactly when the holding stage is free. Take a write sampled at edge E0 into an empty path: the holding stage loads at E1, which clears `hold_empty`. It passes to the shift stage at E2, which sets `hold_empty` again and drives the start bit. The holding stage refills from the queue on the edge after it hands over.
- R6: If the holding stage is occupied when a stop bit ends, the next start bit begins on that same edge. The start of one frame and the start of the next are then exactly (frame bits x OSR) ticks apart.
- R7: Accepted bytes leave in write order. While the shift stage is busy, the queue and holding stage together accept FIFO_DEPTH+1 bytes. A write while the queue is full is dropped and sets `overrun`, which stays 1 until reset.
- R8: `line_idle` is 1 only when the queue, the holding stage and the shift stage are all empty. `txd` is 1 whenever `line_idle` is 1.
- R9: The configuration inputs are captured when a frame starts. A change during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to send |
| cfg_wsize | input | 2 | Data bit count select (5..8) |
| cfg_par_on | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| baud_tick | input | 1 | One pulse per sub-bit time slot |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding stage is free |
| line_idle | output | 1 | Whole path drained, line idle |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
The bench builds the block with its defaults, FIFO_DEPTH = 4 and OSR = 16. With a queue of four entries, a burst of seven writes behind a busy frame overflows the path, so the capacity edge and the overrun flag are reached quickly. Bursts of up to five bytes keep the holding stage occupied across frame boundaries, which exercises the back-to-back start of R6. Sixteen ticks per bit let the bench sample every bit at its centre. Changing the tick density between bursts shows that bit length is counted in ticks, not clock cycles.

// File: rtl/utx_pkg.sv
// Shared types and helpers for the buffered serial transmitter.
// Assumes byte-wide host data and a 2-bit word-size code (5..8 bits).
package utx_pkg;

    localparam int BYTE_W = 8;

    // Frame sequencer states.
    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_START = 3'd1,
        TX_DATA  = 3'd2,
        TX_PAR   = 3'd3,
        TX_STOP  = 3'd4
    } tx_state_e;

    // Per-frame configuration, captured at frame start.
    typedef struct packed {
        logic [1:0] wsize;
        logic       par_on;
        logic       par_odd;
    } frame_cfg_t;

    // Mask selecting the data bits that are sent for a word-size code.
    function automatic logic [BYTE_W-1:0] wsize_mask(input logic [1:0] ws);
        return {BYTE_W{1'b1}} >> (2'd3 - ws);
    endfunction

    // Index of the last data bit sent for a word-size code.
    function automatic logic [2:0] wsize_last(input logic [1:0] ws);
        return 3'd4 + {1'b0, ws};
    endfunction

    // Parity bit over the sent data bits.
    function automatic logic frame_parity(input logic [BYTE_W-1:0] d,
                                          input logic [1:0] ws,
                                          input logic odd);
        return (^(d & wsize_mask(ws))) ^ odd;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
// Write queue ahead of the holding stage.
// Fall-through read: dout shows the oldest entry while not empty.
// A push while full is ignored here; the top flags it.
// Assumes DEPTH >= 2.
module utx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slot_q[rd_ptr];

    // One storage register per slot, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (do_push && wr_ptr == PTR_W'(i))
                slot_q[i] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/utx_hold.sv
// One-byte holding stage between the queue and the shift stage.
// Refills from the queue on any cycle it is free. It is therefore
// free for one cycle after each handover. take and pop never coincide,
// because take requires the stage to be occupied.
module utx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_dout,
    input  logic         take,
    output logic         pop,
    output logic         hold_valid,
    output logic [W-1:0] hold_data
);
    assign pop = !hold_valid && !fifo_empty;

    // Load from the queue when free; release when the shift stage takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (take) begin
            hold_valid <= 1'b0;
        end else if (pop) begin
            hold_valid <= 1'b1;
            hold_data  <= fifo_dout;
        end
    end

endmodule

// File: rtl/utx_shifter.sv
// Shift stage and frame sequencer. It takes a byte from the holding stage
// when idle, or on the last tick of a stop bit (back to back). It then sends
// start, data (LSB first), optional parity and stop. Each bit lasts OSR
// baud ticks. Configuration is captured at take.
module utx_shifter
    import utx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_valid,
    input  logic [BYTE_W-1:0] hold_data,
    input  frame_cfg_t        cfg,
    output logic              take,
    output logic              txd,
    output logic              busy
);
    localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(OSR - 1);

    tx_state_e         state;
    logic [TW-1:0]     tick_cnt;
    logic [2:0]        bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              par_bit;
    frame_cfg_t        cfg_l;
    logic              bit_end;

    assign busy    = (state != TX_IDLE);
    assign bit_end = busy && baud_tick && (tick_cnt == TICK_LAST);
    assign take    = hold_valid && ((state == TX_IDLE) || (state == TX_STOP && bit_end));

    // Line level chosen by the current frame position.
    always_comb begin
        case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    // Frame sequencing: load on take, advance one bit every OSR ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            cfg_l    <= '0;
        end else if (take) begin
            state    <= TX_START;
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= hold_data;
            par_bit  <= frame_parity(hold_data, cfg.wsize, cfg.par_odd);
            cfg_l    <= cfg;
        end else if (busy && baud_tick) begin
            if (tick_cnt == TICK_LAST) begin
                tick_cnt <= '0;
                case (state)
                    TX_START: begin
                        state   <= TX_DATA;
                        bit_idx <= '0;
                    end
                    TX_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == wsize_last(cfg_l.wsize))
                            state <= cfg_l.par_on ? TX_PAR : TX_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end
                    TX_PAR:  state <= TX_STOP;
                    default: state <= TX_IDLE;
                endcase
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_tx_pipe.sv
// Buffered serial transmitter top: queue -> holding stage -> shift stage.
// Produces status flags for the holding stage, for full drain, and a sticky
// overrun. Assumes baud_tick is a single-cycle pulse synchronous to clk.
module uart_tx_pipe
    import utx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int OSR        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        cfg_wsize,
    input  logic              cfg_par_on,
    input  logic              cfg_par_odd,
    input  logic              baud_tick,
    output logic              txd,
    output logic              hold_empty,
    output logic              line_idle,
    output logic              overrun
);
    logic              fifo_empty, fifo_full, fifo_pop;
    logic [BYTE_W-1:0] fifo_dout;
    logic              hold_valid, hold_take, tx_busy;
    logic [BYTE_W-1:0] hold_data;
    frame_cfg_t        cfg_now;

    assign cfg_now = '{wsize: cfg_wsize, par_on: cfg_par_on, par_odd: cfg_par_odd};

    utx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    utx_hold #(.W(BYTE_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .take       (hold_take),
        .pop        (fifo_pop),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    utx_shifter #(.OSR(OSR)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .cfg        (cfg_now),
        .take       (hold_take),
        .txd        (txd),
        .busy       (tx_busy)
    );

    assign hold_empty = !hold_valid;
    assign line_idle  = fifo_empty && !hold_valid && !tx_busy;

    // Sticky record of a write lost to a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (wr_en && fifo_full)
            overrun <= 1'b1;
    end

endmodule

// File: rtl/utx_checker.sv
// Property checks for uart_tx_pipe, attached by bind.
module utx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic baud_tick,
    input logic txd,
    input logic hold_empty,
    input logic line_idle,
    input logic overrun,
    input logic fifo_full,
    input logic fifo_empty,
    input logic hold_take
);
    // R2: the line moves only on a tick or at a frame start.
    a_r2_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !hold_take) |=> $stable(txd));

    // R5: a free holding stage with queued data is filled on the next edge.
    a_r5_hold_refills: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_empty && !fifo_empty) |=> !hold_empty);

    // R7: a write into a full queue raises overrun.
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full) |=> overrun);

    // R7: overrun is sticky.
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R8: an idle path has a free holding stage and a high line.
    a_r8_idle_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle |-> (hold_empty && txd));

endmodule

bind uart_tx_pipe utx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .baud_tick  (baud_tick),
    .txd        (txd),
    .hold_empty (hold_empty),
    .line_idle  (line_idle),
    .overrun    (overrun),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .hold_take  (hold_take)
);

// File: tb/sim_uart_tx_pipe.sv
// Bench for uart_tx_pipe: directed corners plus seeded random bursts.
// A line monitor decodes frames at bit centres and compares them with
// frames predicted from the requirements.
module sim_uart_tx_pipe;
    localparam int DEPTH = 4;
    localparam int OSR   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_wsize = 2'b11;
    logic       cfg_par_on = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, hold_empty, line_idle, overrun;

    int n_checks = 0;
    int n_fails  = 0;
    int tdiv     = 1;

    typedef struct {
        logic [7:0] d;
        logic [1:0] ws;
        logic       pe;
        logic       po;
        logic       b2b;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    uart_tx_pipe #(.FIFO_DEPTH(DEPTH), .OSR(OSR)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_wsize(cfg_wsize), .cfg_par_on(cfg_par_on), .cfg_par_odd(cfg_par_odd),
        .baud_tick(baud_tick), .txd(txd), .hold_empty(hold_empty),
        .line_idle(line_idle), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected frame bits (bit 0 = start) and length, from R2/R3/R4.
    function automatic int frame_len(input exp_t e);
        return 2 + 5 + int'(e.ws) + (e.pe ? 1 : 0);
    endfunction

    function automatic logic [11:0] frame_bits(input exp_t e);
        logic [11:0] b;
        int          nd;
        logic        p;
        nd = 5 + int'(e.ws);
        b  = '0;
        p  = e.po;
        for (int i = 0; i < nd; i++) begin
            b[1+i] = e.d[i];
            p      = p ^ e.d[i];
        end
        if (e.pe) begin
            b[1+nd] = p;
            b[2+nd] = 1'b1;
        end else begin
            b[1+nd] = 1'b1;
        end
        return b;
    endfunction

    // Tick generator: density set by tdiv.
    always @(negedge clk) begin
        if (tdiv <= 1) baud_tick = 1'b1;
        else           baud_tick = ($urandom_range(tdiv - 1, 0) == 0);
    end

    // Line monitor: counts ticks, finds starts, samples bit centres.
    int          gtick = 0, mticks = 0, kbit = 0, nb = 0, prev_nb = 0, last_start = 0;
    bit          mon_act = 1'b0;
    exp_t        cur;
    logic [11:0] got;
    always begin
        @(posedge clk);
        #1;
        if (!rst_n) begin
            mon_act = 1'b0;
        end else begin
            if (baud_tick) begin
                gtick++;
                if (mon_act) mticks++;
            end
            if (!mon_act) begin
                if (txd == 1'b0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected frame start", 32'd1, 32'd0);
                        cur = '{d: 8'h00, ws: 2'b11, pe: 1'b0, po: 1'b0, b2b: 1'b0};
                    end else begin
                        cur = exp_q.pop_front();
                    end
                    if (cur.b2b)
                        chk((gtick - last_start) == prev_nb * OSR, "R6 back-to-back gap",
                            gtick - last_start, prev_nb * OSR);
                    last_start = gtick;
                    nb = frame_len(cur);
                    prev_nb = nb;
                    mon_act = 1'b1;
                    mticks = 0;
                    kbit = 0;
                    got = '0;
                end
            end else if (baud_tick && mticks == kbit * OSR + OSR / 2) begin
                got[kbit] = txd;
                kbit++;
                if (kbit == nb) begin
                    mon_act = 1'b0;
                    chk(got == frame_bits(cur), "R2 R3 R4 frame bits", got, frame_bits(cur));
                end
            end
        end
    end

    // Queue one write at the current negedge; the next posedge samples it.
    task automatic put(input logic [7:0] d, input bit b2b, input bit accepted);
        wr_en   = 1'b1;
        wr_data = d;
        if (accepted)
            exp_q.push_back('{d: d, ws: cfg_wsize, pe: cfg_par_on, po: cfg_par_odd, b2b: b2b});
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!line_idle);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state.
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
        chk(line_idle == 1'b1, "R1 line_idle", line_idle, 1);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);

        // R5/R8/R2: pipeline fill timing for one write, 8 bits no parity.
        @(negedge clk);
        put(8'hA5, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk(line_idle == 1'b0, "R8 busy after write", line_idle, 0);
        chk(hold_empty == 1'b1, "R5 hold free at E0", hold_empty, 1);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        chk(hold_empty == 1'b0, "R5 hold loaded at E1", hold_empty, 0);
        @(posedge clk); #1;
        chk(hold_empty == 1'b1, "R5 hold handed over at E2", hold_empty, 1);
        chk(txd == 1'b0, "R2 start bit at E2", txd, 0);
        wait_idle();

        // R9: config change mid-frame does not alter the frame in flight.
        cfg_wsize = 2'b11; cfg_par_on = 1'b0; cfg_par_odd = 1'b0;
        put(8'h3C, 1'b0, 1'b1);
        @(negedge clk); wr_en = 1'b0;
        repeat (40) @(negedge clk);
        cfg_wsize = 2'b00; cfg_par_on = 1'b1; cfg_par_odd = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R9 frame with captured config consumed", exp_q.size(), 0);

        // R6/R3/R4: back-to-back burst, 7 bits even parity.
        cfg_wsize = 2'b10; cfg_par_on = 1'b1; cfg_par_odd = 1'b0;
        put(8'h81, 1'b0, 1'b1); @(negedge clk);
        put(8'h7E, 1'b1, 1'b1); @(negedge clk);
        put(8'hF0, 1'b1, 1'b1); @(negedge clk);
        wr_en = 1'b0;
        wait_idle();

        // R7: capacity and overrun behind a busy frame, 5 bits odd parity.
        cfg_wsize = 2'b00; cfg_par_on = 1'b1; cfg_par_odd = 1'b1;
        put(8'h11, 1'b0, 1'b1); @(negedge clk);
        wr_en = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < DEPTH + 3; i++) begin
            put(8'h20 + 8'(i), 1'b1, i < DEPTH + 1);
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(posedge clk); #1;
        chk(overrun == 1'b1, "R7 overrun after drop", overrun, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R7 accepted bytes all sent", exp_q.size(), 0);
        chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

        // Random bursts with random config and tick density.
        for (int b = 0; b < 20; b++) begin
            int n;
            cfg_wsize   = 2'($urandom_range(3, 0));
            cfg_par_on  = 1'($urandom_range(1, 0));
            cfg_par_odd = 1'($urandom_range(1, 0));
            tdiv        = $urandom_range(2, 1);
            n           = $urandom_range(DEPTH + 1, 1);
            for (int i = 0; i < n; i++) begin
                put(8'($urandom_range(255, 0)), i > 0, 1'b1);
                @(negedge clk);
            end
            wr_en = 1'b0;
            wait_idle();
        end
        tdiv = 1;

        // R8: everything drained.
        @(posedge clk); #1;
        chk(exp_q.size() == 0, "R7 no frame missing", exp_q.size(), 0);
        chk(line_idle == 1'b1 && txd == 1'b1, "R8 idle line high", {line_idle, txd}, 2'b11);
        chk(hold_empty == 1'b1, "R5 hold free at end", hold_empty, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule